// File: doc/BRIEF.md
# Bus Controller Operation Sequencer

This block is the front end of a serial avionics bus controller. A host selects one of four operations with a 2-bit code and starts it with a low-going strobe. Depending on the operation, the block fetches a command word or a data word from external byte-wide latches, or it waits for a word coming back from the bus. Fetched words go to a one-word transmit holding buffer. A downstream word transmitter adds the sync pattern and sends the word. Received words arrive from an abstracted decoder already validated. They are routed to the host as two byte phases, on one of three strobes: status, mode data or ordinary data.

For a normal exchange the block reads the direction bit and the word count from the command it has just fetched. When the terminal is told to receive, the block fetches and queues the outgoing data words. When the terminal is told to transmit, the block passes the returned data words to the host and marks a complete block with a good-block pulse. A terminal-to-terminal transfer is built by chaining a single-command operation with a normal exchange. A passive monitor mode forwards every word seen on the selected bus.

Top module: `bcOpSequencer`

## Requirements
- R1: An operation is accepted on the first clock edge at which `opStrobeN` is sampled low after being sampled high, provided the block is idle and `noDataReq` is high. `opSel` and `busSelIn` are captured on that edge, and `activeBus` then shows the captured bus. Select codes: 0 normal exchange, 1 single command word, 2 data word, 3 receive-and-identify.
- R2: Codes 0 and 1 fetch a command word. `latchCmdEn` is held for two cycles, with `latchHighSel` high in the first cycle (high byte) and low in the second. The word is then offered on `txWord` with `txCmdSync`=1 and `txParity` set so that the 17 bits have odd parity.
- R3: Code 2 fetches one word the same way through `latchDataEn` and offers it with `txCmdSync`=0. The operation then ends.
- R4: `txValid` stays high, with `txWord` held, until a cycle with `txReady` high. `noDataReq` is low exactly while a word is waiting and returns high once the word is taken.
- R5: In code 0, when command bit 10 is 0, the block queues the command and then fetches and queues N data words one after another, where N is command bits 4:0 and a value of 0 means 32. The operation ends when the next command/status-sync word is received.
- R6: In code 0, when command bit 10 is 1, the block queues the command and waits for a status word. The next N data-sync words go out on `dataStrb`. `goodBlock` pulses for one cycle, together with the low-byte phase of the last word, and the operation ends.
- R7: In code 3 with `monitorEn` low, the first data-sync word received goes out on `modeDataStrb` and ends the operation.
- R8: A received word with `rxCmdSync`=1 always goes out on `statusStrb`. A data-sync word received while no operation is waiting for data produces no host strobe.
- R9: In code 3 with `monitorEn` high, every data-sync word goes out on `modeDataStrb` until `monitorEn` is low, after which the block returns to idle.
- R10: A strobe edge that arrives while an operation is in progress, or while `noDataReq` is low, is ignored: no fetch and no change of `activeBus`. It sets `protoErr`, which stays high until reset.
- R11: Each forwarded word takes two consecutive cycles on a single strobe. In the first cycle `hostHigh`=1 and `hostByte` carries bits 15:8; in the second `hostHigh`=0 and `hostByte` carries bits 7:0. At most one of the three strobes is high at a time. Received words are at least two cycles apart.
- R12: After reset `noDataReq`=1 and `txValid`, `protoErr`, `goodBlock`, all host strobes and both latch enables are 0.
- R13: A single-command operation followed by a normal exchange, with the second strobe issued after `noDataReq` has fallen and risen again, sends both commands in order and handles the exchange as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 2 | Operation select, bit 0 is line A |
| opStrobeN | input | 1 | Operation start strobe, acts on falling edge |
| busSelIn | input | 2 | Bus selection, captured at start |
| monitorEn | input | 1 | Passive monitor request for code 3 |
| latchByte | input | 8 | Byte returned by the external latches |
| latchCmdEn | output | 1 | Enable of the command-word latch |
| latchDataEn | output | 1 | Enable of the data-word latch |
| latchHighSel | output | 1 | High (1) or low (0) byte select for latch reads |
| txWord | output | 16 | Word offered to the transmitter |
| txCmdSync | output | 1 | 1: command/status sync, 0: data sync |
| txParity | output | 1 | Odd parity bit for txWord |
| txValid | output | 1 | Transmit word waiting |
| txReady | input | 1 | Transmitter takes the waiting word |
| rxValid | input | 1 | Validated received word present |
| rxWord | input | 16 | Received word |
| rxCmdSync | input | 1 | Received word had command/status sync |
| hostByte | output | 8 | Byte of a forwarded word |
| hostHigh | output | 1 | hostByte holds the high byte |
| statusStrb | output | 1 | Command/status word strobe |
| modeDataStrb | output | 1 | Mode data word strobe |
| dataStrb | output | 1 | Ordinary data word strobe |
| goodBlock | output | 1 | Received block complete |
| noDataReq | output | 1 | Low while a transmit word is waiting |
| activeBus | output | 2 | Bus captured by the last accepted operation |
| protoErr | output | 1 | Sticky ignored-strobe flag |

## Verification
Each select code is started with distinct latch contents, so that the sync flag and word order on the transmit side reveal which source was fetched. Normal exchanges are run with both values of the direction bit and with word counts of 3, 2, 1 and 0. The zero count tells the 32-word case apart from a literal zero. Received traffic mixes status-sync and data-sync words across idle, identify, monitor and block-receive states, so the chosen strobe shows the routing state. Illegal strobes are issued once during a busy wait and once while the transmit buffer is stalled full, and the bench then checks `activeBus`, the data fetch count and the transmit stream for any effect.

// File: rtl/bcSeqPkg.sv
`timescale 1ns/1ps
package bcSeqPkg;

  typedef enum logic [1:0] {
    OP_EXCHANGE  = 2'd0,
    OP_MODE_CMD  = 2'd1,
    OP_MODE_DATA = 2'd2,
    OP_IDENTIFY  = 2'd3
  } opCode_e;

  typedef enum logic [1:0] {
    HOST_NONE     = 2'd0,
    HOST_STATUS   = 2'd1,
    HOST_MODEDATA = 2'd2,
    HOST_DATA     = 2'd3
  } hostKind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_HI,
    S_FETCH_LO,
    S_WAIT_EMPTY,
    S_AWAIT_STATUS,
    S_RX_DATA,
    S_AWAIT_MODE,
    S_MONITOR
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      fetchCmd;
    logic      fetchData;
    logic      fetchHigh;
    logic      pushTx;
    logic      pushCmdSync;
    logic      loadCmd;
    logic      countWord;
    logic      hostStart;
    hostKind_e hostKind;
    logic      blockGood;
  } seqCtrl_t;

endpackage

// File: rtl/bcSeqControl.sv
`timescale 1ns/1ps
module bcSeqControl
  import bcSeqPkg::*;
#(
  parameter int BUS_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opSel,
  input  logic             opStrobeN,
  input  logic [BUS_W-1:0] busSelIn,
  input  logic             monitorEn,
  input  logic             rxValid,
  input  logic             rxCmdSync,
  input  logic             bufFull,
  input  logic             cmdDirTx,
  input  logic             lastWord,
  output seqCtrl_t         ctrl,
  output logic [BUS_W-1:0] activeBus,
  output logic             protoErr
);

  seqState_e  state, stateNext;
  opCode_e    opReg;
  logic       strbPrev;
  logic       fetchingCmd;
  logic       dirTx;
  logic       strbFall;
  logic       accept;

  assign strbFall = strbPrev && !opStrobeN;
  assign accept   = strbFall && (state == S_IDLE) && !bufFull;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (accept) begin
          if (opCode_e'(opSel) == OP_IDENTIFY)
            stateNext = monitorEn ? S_MONITOR : S_AWAIT_MODE;
          else
            stateNext = S_FETCH_HI;
        end
      end
      S_FETCH_HI: begin
        ctrl.fetchCmd  = fetchingCmd;
        ctrl.fetchData = !fetchingCmd;
        ctrl.fetchHigh = 1'b1;
        stateNext      = S_FETCH_LO;
      end
      S_FETCH_LO: begin
        ctrl.fetchCmd    = fetchingCmd;
        ctrl.fetchData   = !fetchingCmd;
        ctrl.pushTx      = 1'b1;
        ctrl.pushCmdSync = fetchingCmd;
        if (opReg != OP_EXCHANGE) begin
          stateNext = S_IDLE;
        end else if (fetchingCmd) begin
          ctrl.loadCmd = 1'b1;
          stateNext    = cmdDirTx ? S_AWAIT_STATUS : S_WAIT_EMPTY;
        end else begin
          ctrl.countWord = 1'b1;
          stateNext      = lastWord ? S_AWAIT_STATUS : S_WAIT_EMPTY;
        end
      end
      S_WAIT_EMPTY: begin
        if (!bufFull) stateNext = S_FETCH_HI;
      end
      S_AWAIT_STATUS: begin
        if (rxValid && rxCmdSync) stateNext = dirTx ? S_RX_DATA : S_IDLE;
      end
      S_RX_DATA: begin
        if (rxValid && !rxCmdSync) begin
          ctrl.countWord = 1'b1;
          if (lastWord) begin
            ctrl.blockGood = 1'b1;
            stateNext      = S_IDLE;
          end
        end
      end
      S_AWAIT_MODE: begin
        if (rxValid && !rxCmdSync) stateNext = S_IDLE;
      end
      S_MONITOR: begin
        if (!monitorEn) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase

    // routing of received words to the host strobes
    if (rxValid) begin
      if (rxCmdSync) begin
        ctrl.hostStart = 1'b1;
        ctrl.hostKind  = HOST_STATUS;
      end else if (state == S_RX_DATA) begin
        ctrl.hostStart = 1'b1;
        ctrl.hostKind  = HOST_DATA;
      end else if ((state == S_AWAIT_MODE) || (state == S_MONITOR)) begin
        ctrl.hostStart = 1'b1;
        ctrl.hostKind  = HOST_MODEDATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      opReg       <= OP_EXCHANGE;
      strbPrev    <= 1'b1;
      fetchingCmd <= 1'b0;
      dirTx       <= 1'b0;
      activeBus   <= '0;
      protoErr    <= 1'b0;
    end else begin
      state    <= stateNext;
      strbPrev <= opStrobeN;
      if (accept) begin
        opReg       <= opCode_e'(opSel);
        activeBus   <= busSelIn;
        fetchingCmd <= (opCode_e'(opSel) != OP_MODE_DATA);
      end else if (strbFall) begin
        protoErr <= 1'b1;
      end
      if (ctrl.loadCmd) begin
        fetchingCmd <= 1'b0;
        dirTx       <= cmdDirTx;
      end
    end
  end

endmodule

// File: rtl/bcSeqDatapath.sv
`timescale 1ns/1ps
module bcSeqDatapath
  import bcSeqPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WC_W    = 5,
  parameter int DIR_BIT = 10,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [BYTE_W-1:0] latchByte,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              txReady,
  output logic              bufFull,
  output logic              cmdDirTx,
  output logic              lastWord,
  output logic [WORD_W-1:0] txWord,
  output logic              txCmdSync,
  output logic              txParity,
  output logic [BYTE_W-1:0] hostByte,
  output logic              hostHigh,
  output logic              statusStrb,
  output logic              modeDataStrb,
  output logic              dataStrb,
  output logic              goodBlock
);

  localparam int CNT_W      = WC_W + 1;
  localparam int DIR_IN_HI  = DIR_BIT - BYTE_W;
  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(1) << WC_W;

  logic [BYTE_W-1:0] hiReg;
  logic [CNT_W-1:0]  wordCnt;
  logic [CNT_W-1:0]  wcTarget;
  logic [WORD_W-1:0] hostWord;
  logic [1:0]        hostPhase;
  hostKind_e         hostKindReg;
  logic              gbPend;
  logic [WC_W-1:0]   wcField;

  assign wcField  = latchByte[WC_W-1:0];
  assign cmdDirTx = hiReg[DIR_IN_HI];
  assign lastWord = (wordCnt + CNT_W'(1)) == wcTarget;
  assign txParity = ~^txWord;

  // byte assembly, word counting and transmit holding buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg     <= '0;
      wordCnt   <= '0;
      wcTarget  <= FULL_COUNT;
      txWord    <= '0;
      txCmdSync <= 1'b0;
      bufFull   <= 1'b0;
    end else begin
      if (ctrl.fetchHigh && (ctrl.fetchCmd || ctrl.fetchData)) hiReg <= latchByte;
      if (ctrl.loadCmd) begin
        wordCnt  <= '0;
        wcTarget <= (wcField == '0) ? FULL_COUNT : {1'b0, wcField};
      end else if (ctrl.countWord) begin
        wordCnt <= wordCnt + CNT_W'(1);
      end
      if (ctrl.pushTx) begin
        txWord    <= {hiReg, latchByte};
        txCmdSync <= ctrl.pushCmdSync;
        bufFull   <= 1'b1;
      end else if (bufFull && txReady) begin
        bufFull <= 1'b0;
      end
    end
  end

  // two-phase host output, high byte first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostWord    <= '0;
      hostPhase   <= 2'd0;
      hostKindReg <= HOST_NONE;
      gbPend      <= 1'b0;
      goodBlock   <= 1'b0;
    end else begin
      gbPend    <= ctrl.blockGood;
      goodBlock <= gbPend;
      if (ctrl.hostStart) begin
        hostWord    <= rxWord;
        hostKindReg <= ctrl.hostKind;
        hostPhase   <= 2'd1;
      end else if (hostPhase == 2'd1) begin
        hostPhase <= 2'd2;
      end else begin
        hostPhase <= 2'd0;
      end
    end
  end

  always_comb begin
    hostHigh = (hostPhase == 2'd1);
    case (hostPhase)
      2'd1:    hostByte = hostWord[WORD_W-1:BYTE_W];
      2'd2:    hostByte = hostWord[BYTE_W-1:0];
      default: hostByte = '0;
    endcase
    statusStrb   = (hostPhase != 2'd0) && (hostKindReg == HOST_STATUS);
    modeDataStrb = (hostPhase != 2'd0) && (hostKindReg == HOST_MODEDATA);
    dataStrb     = (hostPhase != 2'd0) && (hostKindReg == HOST_DATA);
  end

endmodule

// File: rtl/bcOpSequencer.sv
`timescale 1ns/1ps
module bcOpSequencer
  import bcSeqPkg::*;
#(
  parameter int BUS_W  = 2,
  parameter int BYTE_W = 8,
  parameter int WC_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          opSel,
  input  logic                opStrobeN,
  input  logic [BUS_W-1:0]    busSelIn,
  input  logic                monitorEn,
  input  logic [BYTE_W-1:0]   latchByte,
  output logic                latchCmdEn,
  output logic                latchDataEn,
  output logic                latchHighSel,
  output logic [2*BYTE_W-1:0] txWord,
  output logic                txCmdSync,
  output logic                txParity,
  output logic                txValid,
  input  logic                txReady,
  input  logic                rxValid,
  input  logic [2*BYTE_W-1:0] rxWord,
  input  logic                rxCmdSync,
  output logic [BYTE_W-1:0]   hostByte,
  output logic                hostHigh,
  output logic                statusStrb,
  output logic                modeDataStrb,
  output logic                dataStrb,
  output logic                goodBlock,
  output logic                noDataReq,
  output logic [BUS_W-1:0]    activeBus,
  output logic                protoErr
);

  seqCtrl_t ctrl;
  logic     bufFull;
  logic     cmdDirTx;
  logic     lastWord;

  bcSeqControl #(.BUS_W(BUS_W)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .opSel     (opSel),
    .opStrobeN (opStrobeN),
    .busSelIn  (busSelIn),
    .monitorEn (monitorEn),
    .rxValid   (rxValid),
    .rxCmdSync (rxCmdSync),
    .bufFull   (bufFull),
    .cmdDirTx  (cmdDirTx),
    .lastWord  (lastWord),
    .ctrl      (ctrl),
    .activeBus (activeBus),
    .protoErr  (protoErr)
  );

  bcSeqDatapath #(.BYTE_W(BYTE_W), .WC_W(WC_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .latchByte    (latchByte),
    .rxWord       (rxWord),
    .txReady      (txReady),
    .bufFull      (bufFull),
    .cmdDirTx     (cmdDirTx),
    .lastWord     (lastWord),
    .txWord       (txWord),
    .txCmdSync    (txCmdSync),
    .txParity     (txParity),
    .hostByte     (hostByte),
    .hostHigh     (hostHigh),
    .statusStrb   (statusStrb),
    .modeDataStrb (modeDataStrb),
    .dataStrb     (dataStrb),
    .goodBlock    (goodBlock)
  );

  assign latchCmdEn   = ctrl.fetchCmd;
  assign latchDataEn  = ctrl.fetchData;
  assign latchHighSel = ctrl.fetchHigh;
  assign txValid      = bufFull;
  assign noDataReq    = !bufFull;

endmodule

// File: rtl/bcOpSequencer_checker.sv
`timescale 1ns/1ps
module bcOpSequencer_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              latchCmdEn,
  input logic              latchDataEn,
  input logic              latchHighSel,
  input logic [WORD_W-1:0] txWord,
  input logic              txCmdSync,
  input logic              txValid,
  input logic              txReady,
  input logic              hostHigh,
  input logic              statusStrb,
  input logic              modeDataStrb,
  input logic              dataStrb,
  input logic              goodBlock,
  input logic              protoErr
);

  logic anyStrb;
  assign anyStrb = statusStrb || modeDataStrb || dataStrb;

  assert_cmd_high_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (latchCmdEn && latchHighSel) |=> (latchCmdEn && !latchHighSel));

  assert_data_high_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (latchDataEn && latchHighSel) |=> (latchDataEn && !latchHighSel));

  assert_one_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(latchCmdEn && latchDataEn));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txWord) && $stable(txCmdSync)));

  assert_good_block_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    goodBlock |-> (dataStrb && !hostHigh));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  assert_low_follows_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrb && hostHigh) |=>
      (!hostHigh && $stable({statusStrb, modeDataStrb, dataStrb})));

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({statusStrb, modeDataStrb, dataStrb}));

endmodule

bind bcOpSequencer bcOpSequencer_checker #(.WORD_W(2 * BYTE_W)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .latchCmdEn   (latchCmdEn),
  .latchDataEn  (latchDataEn),
  .latchHighSel (latchHighSel),
  .txWord       (txWord),
  .txCmdSync    (txCmdSync),
  .txValid      (txValid),
  .txReady      (txReady),
  .hostHigh     (hostHigh),
  .statusStrb   (statusStrb),
  .modeDataStrb (modeDataStrb),
  .dataStrb     (dataStrb),
  .goodBlock    (goodBlock),
  .protoErr     (protoErr)
);

// File: tb/bcOpSequencer_test.sv
`timescale 1ns/1ps
module bcOpSequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        opStrobeN = 1'b1;
  logic [1:0]  busSelIn = 2'd0;
  logic        monitorEn = 1'b0;
  logic [7:0]  latchByte;
  logic        latchCmdEn, latchDataEn, latchHighSel;
  logic [15:0] txWord;
  logic        txCmdSync, txParity, txValid;
  logic        txReady = 1'b0;
  logic        rxValid = 1'b0;
  logic [15:0] rxWord = 16'h0;
  logic        rxCmdSync = 1'b0;
  logic [7:0]  hostByte;
  logic        hostHigh, statusStrb, modeDataStrb, dataStrb, goodBlock;
  logic        noDataReq;
  logic [1:0]  activeBus;
  logic        protoErr;

  always #2.5 clk = ~clk;

  bcOpSequencer uut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opStrobeN(opStrobeN),
    .busSelIn(busSelIn), .monitorEn(monitorEn), .latchByte(latchByte),
    .latchCmdEn(latchCmdEn), .latchDataEn(latchDataEn), .latchHighSel(latchHighSel),
    .txWord(txWord), .txCmdSync(txCmdSync), .txParity(txParity), .txValid(txValid),
    .txReady(txReady), .rxValid(rxValid), .rxWord(rxWord), .rxCmdSync(rxCmdSync),
    .hostByte(hostByte), .hostHigh(hostHigh), .statusStrb(statusStrb),
    .modeDataStrb(modeDataStrb), .dataStrb(dataStrb), .goodBlock(goodBlock),
    .noDataReq(noDataReq), .activeBus(activeBus), .protoErr(protoErr)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R12";

  // external latch models
  logic [15:0] cmdLatch = 16'h0;
  int          dataIdx = 0;
  int          expIdx = 0;
  logic        lowPend = 1'b0;
  logic [15:0] dataVal;
  assign dataVal   = 16'h5A00 + dataIdx[15:0];
  assign latchByte = latchCmdEn  ? (latchHighSel ? cmdLatch[15:8] : cmdLatch[7:0]) :
                     latchDataEn ? (latchHighSel ? dataVal[15:8]  : dataVal[7:0])  : 8'h00;

  logic [16:0] txExp[$];
  logic [17:0] hostExp[$];
  bit          stall = 1'b0;
  int          gbCount = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // data latch advances after each completed low-byte read
  initial begin
    forever begin
      @(negedge clk);
      if (lowPend) dataIdx++;
      lowPend = latchDataEn && !latchHighSel;
    end
  end

  // transmitter model and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (txReady) begin
        txReady = 1'b0;
        chk(noDataReq == 1'b1, "R4", "noDataReq after word taken", noDataReq, 1);
      end else if (txValid && !stall) begin
        if (txExp.size() == 0) begin
          chk(1'b0, "R10", "unexpected transmit word", {txCmdSync, txWord}, 0);
        end else begin
          logic [16:0] e;
          e = txExp.pop_front();
          chk({txCmdSync, txWord} == e, curReq, "transmit word and sync", {txCmdSync, txWord}, e);
          chk(txParity == ~^txWord, "R2", "odd parity", txParity, ~^txWord);
          chk(noDataReq == 1'b0, "R4", "noDataReq while word waits", noDataReq, 0);
        end
        txReady = 1'b1;
      end
    end
  end

  // host output monitor and scoreboard
  initial begin
    logic [7:0] hiTmp;
    logic [1:0] kindTmp;
    bit         sawHigh;
    sawHigh = 1'b0;
    hiTmp = 8'h0;
    kindTmp = 2'd0;
    forever begin
      logic [1:0] kindNow;
      @(negedge clk);
      kindNow = statusStrb ? 2'd1 : modeDataStrb ? 2'd2 : dataStrb ? 2'd3 : 2'd0;
      if (goodBlock) gbCount++;
      if (kindNow != 2'd0) begin
        if (hostHigh) begin
          hiTmp = hostByte;
          kindTmp = kindNow;
          sawHigh = 1'b1;
        end else begin
          chk(sawHigh && (kindTmp == kindNow), "R11", "low phase follows high on same strobe",
              kindNow, kindTmp);
          if (hostExp.size() == 0) begin
            chk(1'b0, "R8", "unexpected host word", {kindNow, hiTmp, hostByte}, 0);
          end else begin
            logic [17:0] e;
            e = hostExp.pop_front();
            chk({kindNow, hiTmp, hostByte} == e, curReq, "host kind and word",
                {kindNow, hiTmp, hostByte}, e);
          end
          sawHigh = 1'b0;
        end
      end
    end
  end

  task automatic strobe(input logic [1:0] op, input logic [1:0] bus);
    @(negedge clk);
    opSel = op;
    busSelIn = bus;
    opStrobeN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    opStrobeN = 1'b1;
    opSel = ~op;
  endtask

  task automatic sendRx(input logic [15:0] w, input logic cs);
    @(negedge clk);
    rxValid = 1'b1;
    rxWord = w;
    rxCmdSync = cs;
    @(negedge clk);
    rxValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expectData();
    txExp.push_back({1'b0, 16'h5A00 + expIdx[15:0]});
    expIdx++;
  endtask

  task automatic drain();
    while (txExp.size() != 0 || txValid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic hostDone(input string req);
    repeat (4) @(negedge clk);
    chk(hostExp.size() == 0, req, "host words outstanding", hostExp.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(noDataReq == 1'b1, "R12", "noDataReq at reset", noDataReq, 1);
    chk(txValid == 1'b0, "R12", "txValid at reset", txValid, 0);
    chk(protoErr == 1'b0, "R12", "protoErr at reset", protoErr, 0);
    chk({statusStrb, modeDataStrb, dataStrb, goodBlock} == 4'b0, "R12", "host strobes at reset",
        {statusStrb, modeDataStrb, dataStrb, goodBlock}, 0);
    chk({latchCmdEn, latchDataEn} == 2'b0, "R12", "latch enables at reset",
        {latchCmdEn, latchDataEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R2: single command word
    curReq = "R2";
    cmdLatch = 16'h2C64;
    txExp.push_back({1'b1, 16'h2C64});
    strobe(2'd1, 2'd2);
    chk(activeBus == 2'd2, "R1", "bus captured", activeBus, 2);
    drain();

    // R3: data word
    curReq = "R3";
    expectData();
    strobe(2'd2, 2'd1);
    chk(activeBus == 2'd1, "R1", "bus captured", activeBus, 1);
    drain();

    // R5: terminal receives 3 words
    curReq = "R5";
    cmdLatch = 16'h0823;
    txExp.push_back({1'b1, 16'h0823});
    repeat (3) expectData();
    strobe(2'd0, 2'd0);
    drain();
    hostExp.push_back({2'd1, 16'h1000});
    sendRx(16'h1000, 1'b1);
    hostDone("R5");

    // R5: word count field 0 means 32
    cmdLatch = 16'h0840;
    txExp.push_back({1'b1, 16'h0840});
    repeat (32) expectData();
    strobe(2'd0, 2'd3);
    drain();
    chk(dataIdx == expIdx, "R5", "data words fetched for count 0", dataIdx, expIdx);
    hostExp.push_back({2'd1, 16'h1800});
    sendRx(16'h1800, 1'b1);
    hostDone("R5");

    // R6: terminal transmits 2 words
    curReq = "R6";
    cmdLatch = 16'h0C42;
    txExp.push_back({1'b1, 16'h0C42});
    strobe(2'd0, 2'd1);
    drain();
    hostExp.push_back({2'd1, 16'h1001});
    sendRx(16'h1001, 1'b1);
    hostExp.push_back({2'd3, 16'hA1B2});
    sendRx(16'hA1B2, 1'b0);
    chk(gbCount == 0, "R6", "no good block before last word", gbCount, 0);
    hostExp.push_back({2'd3, 16'hC3D4});
    sendRx(16'hC3D4, 1'b0);
    hostDone("R6");
    chk(gbCount == 1, "R6", "good block after last word", gbCount, 1);

    // R8: idle routing
    curReq = "R8";
    sendRx(16'h7777, 1'b0);
    hostDone("R8");
    hostExp.push_back({2'd1, 16'h2222});
    sendRx(16'h2222, 1'b1);
    hostDone("R8");

    // R7: identify a mode data word, then op ends
    curReq = "R7";
    strobe(2'd3, 2'd2);
    hostExp.push_back({2'd2, 16'hBEEF});
    sendRx(16'hBEEF, 1'b0);
    sendRx(16'h4444, 1'b0);
    hostDone("R7");

    // R9: passive monitor
    curReq = "R9";
    monitorEn = 1'b1;
    strobe(2'd3, 2'd1);
    hostExp.push_back({2'd2, 16'h1111});
    sendRx(16'h1111, 1'b0);
    hostExp.push_back({2'd1, 16'h0C21});
    sendRx(16'h0C21, 1'b1);
    hostExp.push_back({2'd2, 16'h3333});
    sendRx(16'h3333, 1'b0);
    monitorEn = 1'b0;
    repeat (3) @(negedge clk);
    sendRx(16'h5555, 1'b0);
    hostDone("R9");

    // R13: chained command then exchange
    curReq = "R13";
    cmdLatch = 16'h1420;
    txExp.push_back({1'b1, 16'h1420});
    strobe(2'd1, 2'd0);
    wait (!noDataReq);
    wait (noDataReq);
    cmdLatch = 16'h0C41;
    txExp.push_back({1'b1, 16'h0C41});
    strobe(2'd0, 2'd0);
    drain();
    hostExp.push_back({2'd1, 16'h2800});
    sendRx(16'h2800, 1'b1);
    hostExp.push_back({2'd3, 16'h9876});
    sendRx(16'h9876, 1'b0);
    hostDone("R13");
    chk(gbCount == 2, "R13", "good block for chained exchange", gbCount, 2);
    chk(protoErr == 1'b0, "R10", "no error for legal strobes", protoErr, 0);

    // R10: strobe while busy
    curReq = "R10";
    strobe(2'd3, 2'd0);
    chk(activeBus == 2'd0, "R1", "bus captured", activeBus, 0);
    strobe(2'd1, 2'd3);
    repeat (3) @(negedge clk);
    chk(protoErr == 1'b1, "R10", "error on busy strobe", protoErr, 1);
    chk(activeBus == 2'd0, "R10", "bus unchanged on ignored strobe", activeBus, 0);
    chk(txValid == 1'b0, "R10", "no fetch on ignored strobe", txValid, 0);
    hostExp.push_back({2'd2, 16'h1357});
    sendRx(16'h1357, 1'b0);
    hostDone("R10");

    // R10: strobe while a word is waiting
    stall = 1'b1;
    cmdLatch = 16'h2468;
    txExp.push_back({1'b1, 16'h2468});
    strobe(2'd1, 2'd1);
    wait (txValid);
    strobe(2'd2, 2'd2);
    repeat (3) @(negedge clk);
    chk(activeBus == 2'd1, "R10", "bus unchanged while buffer full", activeBus, 1);
    stall = 1'b0;
    drain();
    chk(dataIdx == expIdx, "R10", "no data fetched by ignored strobe", dataIdx, expIdx);
    chk(protoErr == 1'b1, "R10", "error stays set", protoErr, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule